// File: doc/BRIEF.md
# PCM Frame Transmit Serial Port

The block sends one 8-bit companded voice sample per frame onto a serial PCM line that behaves as an open drain. The bit clock and the transmit frame sync come from outside. A fast system clock samples both, and each passes through a synchronizer before the block uses it. The encoder side delivers parallel bytes with a one-cycle valid strobe. The block keeps the most recent byte. When a frame sync rises, it loads that byte, or an idle code if no new byte has arrived since the last frame. It then shifts the byte out most significant digit first, one bit per bit-clock period, and releases the line as soon as the eighth bit ends.

The line is driven only during the eight bit periods. At all other times it is released, which means `line_oe` is low and `line_bit` reads 1 through the external pull-up. The line is also released while the power-control pin is low. It stays released during power saving, a state the block enters on its own when the bit clock or the frame sync stops toggling. With the law-select pin high, the block inverts the even-numbered bits of each byte on the way out.

The controller is a four-state machine:
- ST_SLEEP: power-down or power saving.
- ST_IDLE: line released, waiting for a sync.
- ST_ARMED: sync seen, waiting for a bit-clock rise.
- ST_SHIFT: driving bits.

Its transitions are:
- any state to ST_SLEEP while the power pin reads low or power saving is active.
- ST_SLEEP to ST_IDLE once both conditions clear.
- ST_IDLE to ST_SHIFT on a sync rise while the bit clock is high.
- ST_IDLE to ST_ARMED on a sync rise while the bit clock is low.
- ST_ARMED to ST_SHIFT on the next bit-clock rise.
- ST_SHIFT to ST_IDLE on the bit-clock rise that ends the eighth bit.

Pin-to-line latency is three system clocks: two synchronizer stages plus the state register.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset, `line_oe` is 0, and it stays 0 until a frame sync rise is seen with the power pin high.
- R2: Each frame drives exactly 8 bits, most significant digit (bit 7) first. `line_bit` changes only after a bit-clock rising edge.
- R3: If the frame sync rises while the bit clock is high, the MSD is driven immediately, without waiting for a bit-clock edge.
- R4: If the frame sync rises while the bit clock is low, the line stays released and the MSD is driven at the next bit-clock rising edge.
- R5: The bit-clock rising edge that ends the eighth bit releases the line (`line_oe` = 0).
- R6: While `pwr_on` is 0, the line is released within three system clocks and no frame starts.
- R7: If the bit clock shows no transition for `BCLK_STATIC_CYC` system clocks, the block enters power saving and releases the line, even in the middle of a frame.
- R8: If the frame sync shows no transition for `SYNC_STATIC_CYC` system clocks, the block enters power saving. The next sync rise ends power saving but sends nothing; the sync after it transmits normally.
- R9: With `law_sel` = 1, the transmitted byte is the stored byte XOR 0x55 (bits 6, 4, 2 and 0 inverted). With `law_sel` = 0, it is sent unchanged. `law_sel` is sampled at the frame sync.
- R10: A byte accepted by `smp_valid` is sent in the next frame. If no byte has arrived since the last frame, the block sends the idle code instead: 0xFF when `law_sel` = 0, 0xD5 when `law_sel` = 1.
- R11: While `line_oe` is 0, `line_bit` is 1, so the block never pulls the line low except in a driven bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset |
| bclk_in | input | 1 | Serial bit clock pin |
| fsync_in | input | 1 | Transmit frame sync pin |
| pwr_on | input | 1 | Power control pin; 0 forces power-down |
| law_sel | input | 1 | Companding law: 0 selects mu-law, 1 selects A-law |
| smp_data | input | 8 | Encoded sample byte from the encoder side |
| smp_valid | input | 1 | One-cycle strobe that accepts `smp_data` |
| line_oe | output | 1 | High while the block drives a data bit |
| line_bit | output | 1 | Data bit; 0 pulls the line low while `line_oe` is 1 |

## Verification
Some properties hold on every cycle, and the assertions check these:
- The bit on the line holds steady between bit-clock rises.
- No more than seven bit-clock rises pass while the line is driven.
- The line comes on only right after a sync or bit-clock rise.
- A low power pin or active power saving always releases the line.
- Power saving ends only on a sync rise.

Other behaviour shows only in the bench's scenarios:
- The byte values, including the A-law masking and the idle codes.
- The two ways the MSD is launched.
- Entering power saving from a frozen bit clock and from a silent sync.
- The sync that ends power saving but sends nothing.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int WORD_BITS = 8;

    typedef logic [WORD_BITS-1:0] pcm_word_t;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ARMED = 2'd2,
        ST_SHIFT = 2'd3
    } tx_state_t;

    // even-numbered bits counted from the MSD (bit 7 is number 1)
    localparam pcm_word_t EVEN_BIT_MASK = 8'h55;
    // positive zero, as stored before law masking
    localparam pcm_word_t MU_IDLE_RAW   = 8'hFF;
    localparam pcm_word_t A_IDLE_RAW    = 8'h80;

endpackage

// File: rtl/pcm_sync_bank.sv
module pcm_sync_bank #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] level_q
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[g]};
                prev  <= chain[STAGES-1];
            end
        end

        assign level[g]   = chain[STAGES-1];
        assign level_q[g] = prev;
    end

endmodule

// File: rtl/pcm_idle_mon.sv
module pcm_idle_mon #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    output logic stalled
);

    localparam int             CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (activity) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stalled = (cnt_q == LIM);

endmodule

// File: rtl/pcm_law_map.sv
module pcm_law_map
    import pcm_tx_pkg::*;
(
    input  logic      law_a,
    input  pcm_word_t raw,
    output pcm_word_t coded
);

    always_comb begin
        coded = raw ^ (law_a ? EVEN_BIT_MASK : '0);
    end

endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
    import pcm_tx_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int BCLK_STATIC_CYC = 2048,
    parameter int SYNC_STATIC_CYC = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bclk_in,
    input  logic       fsync_in,
    input  logic       pwr_on,
    input  logic       law_sel,
    input  logic [7:0] smp_data,
    input  logic       smp_valid,
    output logic       line_oe,
    output logic       line_bit
);

    localparam int               IDX_W    = $clog2(WORD_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BITS - 1);

    // ---- pin conditioning ----
    logic [2:0] pin_lvl;
    logic [2:0] pin_prev;

    pcm_sync_bank #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pwr_on, fsync_in, bclk_in}),
        .level    (pin_lvl),
        .level_q  (pin_prev)
    );

    logic bclk_lvl, bclk_rise, bclk_act;
    logic fs_rise, fs_act;
    logic pdn_lvl;

    assign bclk_lvl  = pin_lvl[0];
    assign bclk_rise = pin_lvl[0] & ~pin_prev[0];
    assign bclk_act  = pin_lvl[0] ^ pin_prev[0];
    assign fs_rise   = pin_lvl[1] & ~pin_prev[1];
    assign fs_act    = pin_lvl[1] ^ pin_prev[1];
    // power pin must read high on two samples before the port wakes
    assign pdn_lvl   = pin_lvl[2] & pin_prev[2];

    // ---- stall detection ----
    logic bclk_stall, sync_stall;

    pcm_idle_mon #(.LIMIT(BCLK_STATIC_CYC)) u_bclk_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .activity (bclk_act),
        .stalled  (bclk_stall)
    );

    pcm_idle_mon #(.LIMIT(SYNC_STATIC_CYC)) u_sync_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .activity (fs_act),
        .stalled  (sync_stall)
    );

    logic saving_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saving_q <= 1'b0;
        end else if (fs_rise && !bclk_stall) begin
            saving_q <= 1'b0;
        end else if (bclk_stall || sync_stall) begin
            saving_q <= 1'b1;
        end
    end

    // ---- sample selection ----
    logic      pend_q;
    pcm_word_t pend_byte_q;
    pcm_word_t raw_pick;
    pcm_word_t coded_pick;

    always_comb begin
        if (smp_valid)   raw_pick = smp_data;
        else if (pend_q) raw_pick = pend_byte_q;
        else             raw_pick = law_sel ? A_IDLE_RAW : MU_IDLE_RAW;
    end

    pcm_law_map u_law (
        .law_a (law_sel),
        .raw   (raw_pick),
        .coded (coded_pick)
    );

    // ---- control FSM ----
    tx_state_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    pcm_word_t        shreg_q;
    logic             frame_start;

    assign frame_start = (state_q == ST_IDLE) && fs_rise && pdn_lvl && !saving_q;

    always_comb begin
        state_d = state_q;
        if (!pdn_lvl || saving_q) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_SLEEP: state_d = ST_IDLE;
                ST_IDLE:  if (fs_rise) state_d = bclk_lvl ? ST_SHIFT : ST_ARMED;
                ST_ARMED: if (bclk_rise) state_d = ST_SHIFT;
                ST_SHIFT: if (bclk_rise && idx_q == LAST_IDX) state_d = ST_IDLE;
                default:  state_d = ST_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_SLEEP;
            idx_q       <= '0;
            shreg_q     <= '1;
            pend_q      <= 1'b0;
            pend_byte_q <= '0;
        end else begin
            state_q <= state_d;

            if (frame_start) begin
                pend_q <= 1'b0;
            end else if (smp_valid) begin
                pend_q      <= 1'b1;
                pend_byte_q <= smp_data;
            end

            if (frame_start) begin
                shreg_q <= coded_pick;
                idx_q   <= '0;
            end else if (state_q == ST_SHIFT && state_d == ST_SHIFT && bclk_rise) begin
                shreg_q <= {shreg_q[WORD_BITS-2:0], 1'b1};
                idx_q   <= idx_q + 1'b1;
            end
        end
    end

    // ---- outputs ----
    always_comb begin
        line_oe  = (state_q == ST_SHIFT);
        line_bit = line_oe ? shreg_q[WORD_BITS-1] : 1'b1;
    end

endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk
    import pcm_tx_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic line_oe,
    input logic line_bit,
    input logic bclk_rise,
    input logic fs_rise,
    input logic pdn_lvl,
    input logic saving_q
);

    localparam int RW = $clog2(WORD_BITS + 1);

    logic [RW-1:0] rises_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rises_q <= '0;
        else if (!line_oe)  rises_q <= '0;
        else if (bclk_rise) rises_q <= rises_q + 1'b1;
    end

    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && $past(line_oe) && !$past(bclk_rise)) |-> $stable(line_bit)); // R2

    AST_EIGHT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> (rises_q < RW'(WORD_BITS))); // R5

    AST_LAUNCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> ($past(fs_rise) || $past(bclk_rise))); // R3

    AST_PDN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_lvl |=> !line_oe); // R6

    AST_SAVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        saving_q |=> !line_oe); // R7

    AST_SAVE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(saving_q) |-> $past(fs_rise)); // R8

endmodule

bind pcm_tx_port pcm_tx_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_oe   (line_oe),
    .line_bit  (line_bit),
    .bclk_rise (bclk_rise),
    .fs_rise   (fs_rise),
    .pdn_lvl   (pdn_lvl),
    .saving_q  (saving_q)
);

// File: tb/sim_pcm_tx_port.sv
module sim_pcm_tx_port;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bclk, fsync, pwr_on, law_sel, smp_valid;
    logic [7:0] smp_data;
    wire        line_oe, line_bit;

    int         n_chk  = 0;
    int         n_fail = 0;
    bit         mon_on = 1'b0;
    bit         done   = 1'b0;
    logic [7:0] expq[$];

    always #5 clk = ~clk;

    pcm_tx_port #(
        .BCLK_STATIC_CYC (32),
        .SYNC_STATIC_CYC (512)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_in   (bclk),
        .fsync_in  (fsync),
        .pwr_on    (pwr_on),
        .law_sel   (law_sel),
        .smp_data  (smp_data),
        .smp_valid (smp_valid),
        .line_oe   (line_oe),
        .line_bit  (line_bit)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver side: stage a byte and push the expected line value
    task automatic give(input logic [7:0] d);
        smp_data  = d;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        expq.push_back(law_sel ? (d ^ 8'h55) : d);
    endtask

    task automatic expect_idle();
        expq.push_back(law_sel ? 8'hD5 : 8'hFF);
    endtask

    // one 16-period frame; bit clock period is 8 system clocks
    task automatic frame(input bit armed, input bit quiet, input string qtag);
        for (int c = 0; c < 128; c++) begin
            bclk  = ((c % 8) < 4);
            fsync = armed ? (c >= 5 && c < 13) : (c >= 1 && c < 9);
            if (!quiet) begin
                if (!armed && c == 4)  chk(line_oe == 1'b1, "R3 MSD driven at sync edge", line_oe, 1);
                if (armed && c == 10)  chk(line_oe == 1'b0, "R4 held until bit clock", line_oe, 0);
                if (armed && c == 12)  chk(line_oe == 1'b1, "R4 MSD at next bit clock", line_oe, 1);
            end else if (c == 40) begin
                chk(line_oe == 1'b0, qtag, line_oe, 0);
            end
            @(negedge clk);
        end
    endtask

    task automatic clocks_only(input int n);
        for (int c = 0; c < n; c++) begin
            bclk  = ((c % 8) < 4);
            fsync = 1'b0;
            @(negedge clk);
        end
    endtask

    // monitor: samples three clocks after each bit-clock fall
    initial begin
        int         cnt;
        logic [7:0] got;
        logic [7:0] e;
        bit         rel;
        cnt = 0; got = '0; rel = 1'b0;
        forever begin
            @(negedge bclk);
            repeat (3) @(negedge clk);
            if (!mon_on) begin
                cnt = 0; rel = 1'b0;
            end else if (rel) begin
                chk(line_oe == 1'b0, "R5 released after eighth bit", line_oe, 0);
                rel = 1'b0; cnt = 0;
            end else if (line_oe) begin
                got = {got[6:0], line_bit};
                cnt++;
                if (cnt == 8) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R2 unexpected frame", got, 0);
                    end else begin
                        e = expq.pop_front();
                        chk(got == e, "R2/R9/R10 frame byte", got, e);
                    end
                    rel = 1'b1;
                end
            end else if (cnt != 0) begin
                chk(1'b0, "R2 short frame", 8'(cnt), 8);
                cnt = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bclk = 1'b0; fsync = 1'b0; pwr_on = 1'b0;
        law_sel = 1'b0; smp_valid = 1'b0; smp_data = '0;
        repeat (5) @(negedge clk);
        chk(line_oe == 1'b0, "R1 released in reset", line_oe, 0);
        chk(line_bit == 1'b1, "R11 bit high in reset", line_bit, 1);
        rst_n  = 1'b1;
        pwr_on = 1'b1;
        repeat (8) @(negedge clk);
        chk(line_oe == 1'b0, "R1 released before sync", line_oe, 0);
        mon_on = 1'b1;

        law_sel = 1'b0; give(8'hA3); frame(1'b0, 1'b0, "");
        chk(line_bit == 1'b1, "R11 bit high between frames", line_bit, 1);
        law_sel = 1'b1; give(8'h80); frame(1'b1, 1'b0, "");
        law_sel = 1'b0; expect_idle(); frame(1'b1, 1'b0, "");
        law_sel = 1'b1; expect_idle(); frame(1'b0, 1'b0, "");
        law_sel = 1'b1; give(8'h00); frame(1'b0, 1'b0, "");
        law_sel = 1'b0; give(8'h5C); frame(1'b1, 1'b0, "");

        // R6: power pin drops mid-frame
        mon_on = 1'b0;
        law_sel = 1'b0;
        for (int c = 0; c < 128; c++) begin
            bclk  = ((c % 8) < 4);
            fsync = (c >= 1 && c < 9);
            if (c == 19) chk(line_oe == 1'b1, "R6 frame running before power-down", line_oe, 1);
            if (c == 20) pwr_on = 1'b0;
            if (c == 24) chk(line_oe == 1'b0, "R6 released by power-down", line_oe, 0);
            @(negedge clk);
        end
        mon_on = 1'b1;
        frame(1'b0, 1'b1, "R6 no frame while powered down");
        pwr_on = 1'b1;
        repeat (8) @(negedge clk);
        expect_idle(); frame(1'b0, 1'b0, "");

        // R7: bit clock freezes high mid-frame
        mon_on = 1'b0;
        for (int c = 0; c < 24; c++) begin
            bclk  = ((c % 8) < 4);
            fsync = (c >= 1 && c < 9);
            @(negedge clk);
        end
        for (int h = 0; h < 70; h++) begin
            bclk  = 1'b1;
            fsync = 1'b0;
            if (h == 20) chk(line_oe == 1'b1, "R7 still driving before limit", line_oe, 1);
            if (h == 45) chk(line_oe == 1'b0, "R7 saving after static bit clock", line_oe, 0);
            @(negedge clk);
        end
        bclk = 1'b0;
        repeat (4) @(negedge clk);
        mon_on = 1'b1;
        frame(1'b0, 1'b1, "R7 wake sync sends nothing");
        law_sel = 1'b1; give(8'h3E); frame(1'b1, 1'b0, "");

        // R8: frame sync goes silent
        clocks_only(700);
        law_sel = 1'b0;
        frame(1'b0, 1'b1, "R8 wake sync sends nothing");
        give(8'h91); frame(1'b0, 1'b0, "");

        repeat (20) @(negedge clk);
        chk(expq.size() == 0, "R2 every expected frame seen", 8'(expq.size()), 0);
        chk(line_oe == 1'b0 && line_bit == 1'b1, "R11 released at end", {line_oe, line_bit}, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule